// File: doc/BRIEF.md
# Flash Page Protection Key Unit

This block decides which pages of a 62 kB on-chip flash may be written and whether the array may be read out through the debug port or the parallel programming path. Two sources of protection are merged. The first is a volatile register that software rewrites whenever it likes; it acts on the next cycle and is lost at reset. The second is a persistent protection word. Software stages a new word, enables key entry in a mode register, supplies a 32-bit key as two 16-bit halves and issues save command 0x0C. The saved word is copied into the active (armed) protection only when the part next passes through reset.

The first successful save onto a blank store records the supplied key. Every later save must present that key again. A stored key of 0xDEADDEAD makes the lock permanent: every later save is refused. Only a mass erase returns the store to its blank all-ones state and removes all protection at once. The flash access path presents a page index and receives a write-protect flag for that page's four-page group, together with a global read-protect flag.

Top module: `flash_prot_unit`

## Requirements
- R1: After reset the volatile register and the staging word are all ones, the mode register and both key halves are zero, and cmdPass and cmdFail are low.
- R2: A write to the volatile register (regSel 0) acts from the next cycle. A cleared bit g (g < 31) protects the pages of group g. A cleared bit 31 raises readProt. Writing ones removes the protection again.
- R3: Page p (7-bit index) belongs to group p/4 and is guarded by word bit p/4, so a word of 0xFFFFFFFD protects pages 4 to 7. Page indices 124 to 127 lie outside the array and always report pageWriteProt high.
- R4: A save is cmdGo with cmdCode 0x0C. It fails (cmdFail for one cycle) unless mode register bit 6 is set and bit 5 is clear. A cmdGo with any other code produces neither cmdPass nor cmdFail.
- R5: While the stored key is all ones, a save with key entry enabled accepts any key. It copies the staging word (regSel 1) and the key {upper half (regSel 3), lower half (regSel 4)} into the persistent store, and cmdPass is high for the one cycle after cmdGo.
- R6: Once a key is stored, a save passes only when the entered key equals the stored key. On a mismatch cmdFail pulses and the stored word and key stay unchanged.
- R7: A saved word does not change pageWriteProt or readProt until the next reset. That reset copies it into the armed protection.
- R8: The effective protection of a group is set when either the volatile bit or the armed bit for that group is cleared.
- R9: When the stored key is 0xDEADDEAD, every save fails, including one that presents 0xDEADDEAD, and the store does not change.
- R10: A mass erase (eraseAll) sets the stored key, the stored word, the armed protection and the volatile register to all ones by the next cycle. A save in the same cycle is dropped, with neither cmdPass nor cmdFail.
- R11: Reset clears the volatile register, but protection armed from the persistent word survives any number of resets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; arms the persistent word |
| blankInitN | input | 1 | Held low at power-up to present a blank persistent store |
| regWe | input | 1 | Register write strobe |
| regSel | input | 3 | Register select: 0 volatile, 1 staging word, 2 mode, 3 key upper half, 4 key lower half |
| regWdata | input | 32 | Register write data (halves and mode use the low 16 bits) |
| cmdGo | input | 1 | Command strobe |
| cmdCode | input | 8 | Command code; 0x0C saves protection |
| eraseAll | input | 1 | Mass erase strobe |
| pageIdx | input | 7 | Page index being accessed |
| pageWriteProt | output | 1 | Page is write protected |
| readProt | output | 1 | Array is read protected |
| cmdPass | output | 1 | One-cycle pulse: save accepted |
| cmdFail | output | 1 | One-cycle pulse: save refused |

## Verification
A corrupted persistent word or key does not show up when it happens. It shows up at the next save, as a wrong cmdPass or cmdFail in the cycle after cmdGo, or at the next reset, as wrong page flags. For that reason the bench issues saves and resets repeatedly and then compares the page flags against the expected ones. A wrong volatile or armed bit shows up on pageWriteProt in the same cycle the page is probed, so full page sweeps expose every group bit.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;

  localparam logic [7:0]  SAVE_CMD   = 8'h0C;
  localparam logic [31:0] PERM_KEY   = 32'hDEADDEAD;
  localparam int          KEY_EN_BIT = 6;
  localparam int          KEY_BAN_BIT = 5;

  typedef enum logic [2:0] {
    SEL_VOL    = 3'd0,
    SEL_STAGE  = 3'd1,
    SEL_MODE   = 3'd2,
    SEL_KEY_HI = 3'd3,
    SEL_KEY_LO = 3'd4
  } regSel_e;

  typedef struct packed {
    logic loadVol;
    logic loadStage;
    logic loadMode;
    logic loadKeyHi;
    logic loadKeyLo;
    logic commit;
    logic wipe;
  } dpStrobe_t;

endpackage

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl
  import flash_prot_pkg::*;
#(
  parameter int KEY_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [2:0]       regSel,
  input  logic             cmdGo,
  input  logic [7:0]       cmdCode,
  input  logic             eraseAll,
  input  logic             keyEnBit,
  input  logic             keyBanBit,
  input  logic [KEY_W-1:0] enteredKey,
  input  logic [KEY_W-1:0] storedKey,
  output dpStrobe_t        strobes,
  output logic             cmdPass,
  output logic             cmdFail
);

  logic isSave;
  logic keyEntryOn;
  logic storeBlank;
  logic storePerm;
  logic keyOk;
  logic failNow;

  assign isSave     = cmdGo && (cmdCode == SAVE_CMD);
  assign keyEntryOn = keyEnBit && !keyBanBit;
  assign storeBlank = &storedKey;
  assign storePerm  = (storedKey == KEY_W'(PERM_KEY));
  assign keyOk      = keyEntryOn && !storePerm && (storeBlank || (enteredKey == storedKey));

  always_comb begin
    strobes           = '0;
    strobes.loadVol   = rstN && regWe && (regSel == SEL_VOL);
    strobes.loadStage = rstN && regWe && (regSel == SEL_STAGE);
    strobes.loadMode  = rstN && regWe && (regSel == SEL_MODE);
    strobes.loadKeyHi = rstN && regWe && (regSel == SEL_KEY_HI);
    strobes.loadKeyLo = rstN && regWe && (regSel == SEL_KEY_LO);
    strobes.wipe      = rstN && eraseAll;
    strobes.commit    = rstN && !eraseAll && isSave && keyOk;
  end

  assign failNow = rstN && !eraseAll && isSave && !keyOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdPass <= 1'b0;
      cmdFail <= 1'b0;
    end else begin
      cmdPass <= strobes.commit;
      cmdFail <= failNow;
    end
  end

  assert_pass_fail_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdPass && cmdFail));

  assert_save_needs_key_mode_R4: assert property (@(posedge clk) disable iff (!rstN)
    (isSave && !eraseAll && !(keyEnBit && !keyBanBit)) |=> cmdFail);

  assert_other_code_silent_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdGo && cmdCode != SAVE_CMD) |=> (!cmdPass && !cmdFail));

  assert_fail_keeps_key_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmdFail |-> $stable(storedKey));

  assert_perm_refuses_R9: assert property (@(posedge clk) disable iff (!rstN)
    (storedKey == KEY_W'(PERM_KEY) && cmdGo && cmdCode == SAVE_CMD && !eraseAll) |=> cmdFail);

endmodule

// File: rtl/flash_prot_datapath.sv
module flash_prot_datapath
  import flash_prot_pkg::*;
#(
  parameter int GROUP_COUNT     = 31,
  parameter int PAGES_PER_GROUP = 4,
  parameter int PAGE_IDX_W      = 7,
  parameter int HALF_W          = 16,
  localparam int WORD_W         = GROUP_COUNT + 1,
  localparam int KEY_W          = 2 * HALF_W,
  localparam int GROUP_SHIFT    = $clog2(PAGES_PER_GROUP),
  localparam int GROUP_IDX_W    = PAGE_IDX_W - GROUP_SHIFT,
  localparam int GROUP_SLOTS    = 2 ** GROUP_IDX_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  blankInitN,
  input  dpStrobe_t             strobes,
  input  logic [WORD_W-1:0]     regWdata,
  input  logic [PAGE_IDX_W-1:0] pageIdx,
  output logic                  keyEnBit,
  output logic                  keyBanBit,
  output logic [KEY_W-1:0]      enteredKey,
  output logic [KEY_W-1:0]      storedKey,
  output logic                  pageWriteProt,
  output logic                  readProt
);

  logic [WORD_W-1:0] volReg;
  logic [WORD_W-1:0] stageReg;
  logic [WORD_W-1:0] armedReg;
  logic [WORD_W-1:0] nvProt;
  logic [KEY_W-1:0]  nvKey;
  logic [HALF_W-1:0] modeReg;
  logic [HALF_W-1:0] keyHiReg;
  logic [HALF_W-1:0] keyLoReg;
  logic [GROUP_SLOTS-1:0]  groupBlocked;
  logic [GROUP_IDX_W-1:0]  groupIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      volReg   <= '1;
      stageReg <= '1;
      modeReg  <= '0;
      keyHiReg <= '0;
      keyLoReg <= '0;
      armedReg <= nvProt;
    end else begin
      if (strobes.wipe) begin
        volReg   <= '1;
        armedReg <= '1;
      end else if (strobes.loadVol) begin
        volReg <= regWdata;
      end
      if (strobes.loadStage) stageReg <= regWdata;
      if (strobes.loadMode)  modeReg  <= regWdata[HALF_W-1:0];
      if (strobes.loadKeyHi) keyHiReg <= regWdata[HALF_W-1:0];
      if (strobes.loadKeyLo) keyLoReg <= regWdata[HALF_W-1:0];
    end
  end

  // persistent store: survives rstN, blanked at power-up or by mass erase
  always_ff @(posedge clk) begin
    if (!blankInitN || strobes.wipe) begin
      nvProt <= '1;
      nvKey  <= '1;
    end else if (strobes.commit) begin
      nvProt <= stageReg;
      nvKey  <= {keyHiReg, keyLoReg};
    end
  end

  assign keyEnBit   = modeReg[KEY_EN_BIT];
  assign keyBanBit  = modeReg[KEY_BAN_BIT];
  assign enteredKey = {keyHiReg, keyLoReg};
  assign storedKey  = nvKey;

  for (genvar g = 0; g < GROUP_SLOTS; g++) begin : gGroup
    if (g < GROUP_COUNT) begin : gReal
      assign groupBlocked[g] = !volReg[g] || !armedReg[g];
    end else begin : gBeyond
      assign groupBlocked[g] = 1'b1;
    end
  end

  assign groupIdx      = pageIdx[PAGE_IDX_W-1:GROUP_SHIFT];
  assign pageWriteProt = groupBlocked[groupIdx];
  assign readProt      = !volReg[WORD_W-1] || !armedReg[WORD_W-1];

  assert_armed_only_at_reset_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(strobes.wipe)) |-> $stable(armedReg));

  assert_commit_loads_word_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.commit) |-> (nvProt == $past(stageReg)));

  assert_erase_blanks_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.wipe) |-> ((&nvKey) && (&nvProt) && (&armedReg) && (&volReg)));

  assert_perm_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(nvKey) == KEY_W'(PERM_KEY) && !$past(strobes.wipe) && $past(blankInitN))
      |-> (nvKey == KEY_W'(PERM_KEY)));

endmodule

// File: rtl/flash_prot_unit.sv
module flash_prot_unit
  import flash_prot_pkg::*;
#(
  parameter int GROUP_COUNT     = 31,
  parameter int PAGES_PER_GROUP = 4,
  parameter int PAGE_IDX_W      = 7,
  parameter int HALF_W          = 16,
  localparam int WORD_W         = GROUP_COUNT + 1,
  localparam int KEY_W          = 2 * HALF_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  blankInitN,
  input  logic                  regWe,
  input  logic [2:0]            regSel,
  input  logic [WORD_W-1:0]     regWdata,
  input  logic                  cmdGo,
  input  logic [7:0]            cmdCode,
  input  logic                  eraseAll,
  input  logic [PAGE_IDX_W-1:0] pageIdx,
  output logic                  pageWriteProt,
  output logic                  readProt,
  output logic                  cmdPass,
  output logic                  cmdFail
);

  dpStrobe_t        strobes;
  logic             keyEnBit;
  logic             keyBanBit;
  logic [KEY_W-1:0] enteredKey;
  logic [KEY_W-1:0] storedKey;

  flash_prot_ctrl #(.KEY_W(KEY_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regSel     (regSel),
    .cmdGo      (cmdGo),
    .cmdCode    (cmdCode),
    .eraseAll   (eraseAll),
    .keyEnBit   (keyEnBit),
    .keyBanBit  (keyBanBit),
    .enteredKey (enteredKey),
    .storedKey  (storedKey),
    .strobes    (strobes),
    .cmdPass    (cmdPass),
    .cmdFail    (cmdFail)
  );

  flash_prot_datapath #(
    .GROUP_COUNT     (GROUP_COUNT),
    .PAGES_PER_GROUP (PAGES_PER_GROUP),
    .PAGE_IDX_W      (PAGE_IDX_W),
    .HALF_W          (HALF_W)
  ) uData (
    .clk           (clk),
    .rstN          (rstN),
    .blankInitN    (blankInitN),
    .strobes       (strobes),
    .regWdata      (regWdata),
    .pageIdx       (pageIdx),
    .keyEnBit      (keyEnBit),
    .keyBanBit     (keyBanBit),
    .enteredKey    (enteredKey),
    .storedKey     (storedKey),
    .pageWriteProt (pageWriteProt),
    .readProt      (readProt)
  );

endmodule

// File: tb/tb_flash_prot_unit.sv
module tb_flash_prot_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        blankInitN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regSel = '0;
  logic [31:0] regWdata = '0;
  logic        cmdGo = 1'b0;
  logic [7:0]  cmdCode = '0;
  logic        eraseAll = 1'b0;
  logic [6:0]  pageIdx = '0;
  logic        pageWriteProt, readProt, cmdPass, cmdFail;

  int checks = 0;
  int fails = 0;

  // behavioural reference state
  logic [31:0] mVol, mStage, mArmed, mNvProt, mNvKey;
  logic [15:0] mMode, mKeyHi, mKeyLo;
  logic        mPass, mFail;
  logic [31:0] oNvProt, oNvKey, oStage, oKey;
  logic [15:0] oMode;
  logic        oKeyOk;

  flash_prot_unit dut (
    .clk(clk), .rstN(rstN), .blankInitN(blankInitN), .regWe(regWe),
    .regSel(regSel), .regWdata(regWdata), .cmdGo(cmdGo), .cmdCode(cmdCode),
    .eraseAll(eraseAll), .pageIdx(pageIdx), .pageWriteProt(pageWriteProt),
    .readProt(readProt), .cmdPass(cmdPass), .cmdFail(cmdFail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    oNvProt = mNvProt; oNvKey = mNvKey; oStage = mStage;
    oKey = {mKeyHi, mKeyLo}; oMode = mMode;
    if (!blankInitN) begin mNvProt = '1; mNvKey = '1; end
    if (!rstN) begin
      mVol = '1; mStage = '1; mMode = '0; mKeyHi = '0; mKeyLo = '0;
      mArmed = oNvProt; mPass = 0; mFail = 0;
    end else begin
      mPass = 0; mFail = 0;
      if (regWe) begin
        case (regSel)
          3'd0: mVol = regWdata;
          3'd1: mStage = regWdata;
          3'd2: mMode = regWdata[15:0];
          3'd3: mKeyHi = regWdata[15:0];
          3'd4: mKeyLo = regWdata[15:0];
          default: ;
        endcase
      end
      if (eraseAll) begin
        mNvProt = '1; mNvKey = '1; mArmed = '1; mVol = '1;
      end else if (cmdGo && cmdCode == 8'h0C) begin
        oKeyOk = oMode[6] && !oMode[5] && (oNvKey != 32'hDEADDEAD) &&
                 ((oNvKey == 32'hFFFFFFFF) || (oKey == oNvKey));
        if (oKeyOk) begin mNvProt = oStage; mNvKey = oKey; mPass = 1; end
        else mFail = 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic modelWp(input logic [6:0] p);
    if (p >= 7'd124) return 1'b1;
    return !mVol[p/4] || !mArmed[p/4];
  endfunction

  task automatic compareModel();
    chk("R8 model pageWriteProt", 32'(pageWriteProt), 32'(modelWp(pageIdx)));
    chk("R2 model readProt", 32'(readProt), 32'(!mVol[31] || !mArmed[31]));
    chk("R5 model cmdPass", 32'(cmdPass), 32'(mPass));
    chk("R6 model cmdFail", 32'(cmdFail), 32'(mFail));
  endtask

  task automatic tick();
    @(negedge clk);
    if (rstN) compareModel();
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    regWe = 1; regSel = sel; regWdata = d;
    tick();
    regWe = 0;
  endtask

  task automatic probe(input logic [6:0] p, input logic exp, input string tag);
    pageIdx = p;
    #1;
    chk(tag, 32'(pageWriteProt), 32'(exp));
  endtask

  task automatic doCmd(input logic [7:0] code, input logic expPass, input logic expFail,
                       input string tag);
    cmdGo = 1; cmdCode = code;
    tick();
    cmdGo = 0;
    chk({tag, " pass"}, 32'(cmdPass), 32'(expPass));
    chk({tag, " fail"}, 32'(cmdFail), 32'(expFail));
  endtask

  task automatic pulseReset();
    rstN = 0;
    tick(); tick();
    rstN = 1;
    tick();
  endtask

  task automatic prepSave(input logic [15:0] mode, input logic [31:0] key,
                          input logic [31:0] word);
    wr(3'd2, {16'h0, mode});
    wr(3'd3, {16'h0, key[31:16]});
    wr(3'd4, {16'h0, key[15:0]});
    wr(3'd1, word);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    blankInitN = 1;
    @(negedge clk);
    rstN = 1;
    tick();
    // R1 reset state
    chk("R1 cmdPass", 32'(cmdPass), 0);
    chk("R1 cmdFail", 32'(cmdFail), 0);
    chk("R1 readProt", 32'(readProt), 0);
    probe(7'd5, 0, "R1 page 5 open");
    probe(7'd124, 1, "R3 page 124 beyond array");
    probe(7'd127, 1, "R3 page 127 beyond array");

    // R2 volatile protection
    wr(3'd0, 32'hFFFFFFFD);
    probe(7'd3, 0, "R3 page 3 open");
    probe(7'd4, 1, "R2 page 4 protected");
    probe(7'd7, 1, "R3 page 7 protected");
    probe(7'd8, 0, "R3 page 8 open");
    wr(3'd0, 32'h7FFFFFFF);
    chk("R2 readProt set", 32'(readProt), 1);
    wr(3'd0, 32'hFFFFFFFF);
    chk("R2 readProt cleared", 32'(readProt), 0);
    probe(7'd4, 0, "R2 page 4 released");

    // R4 key mode and other codes
    doCmd(8'h0C, 0, 1, "R4 save without key mode");
    doCmd(8'h05, 0, 0, "R4 other code silent");
    prepSave(16'h0060, 32'h12345678, 32'h7FFFFFFB);
    doCmd(8'h0C, 0, 1, "R4 mode bit5 set");

    // R5 blank store takes key
    wr(3'd2, 32'h40);
    doCmd(8'h0C, 1, 0, "R5 save on blank store");
    probe(7'd8, 0, "R7 not armed before reset");
    chk("R7 readProt not armed", 32'(readProt), 0);
    pulseReset();
    probe(7'd9, 1, "R7 armed after reset");
    chk("R7 readProt armed", 32'(readProt), 1);
    probe(7'd4, 0, "R7 page 4 open");

    // R8 OR of sources, R11 volatile lost
    wr(3'd0, 32'hFFFFFFFE);
    probe(7'd0, 1, "R8 volatile group 0");
    probe(7'd10, 1, "R8 armed group 2");
    pulseReset();
    probe(7'd0, 0, "R11 volatile lost at reset");
    probe(7'd11, 1, "R11 armed survives reset");

    // R6 mismatch
    prepSave(16'h0040, 32'h12340000, 32'hFFFFFFFF);
    doCmd(8'h0C, 0, 1, "R6 wrong key");
    pulseReset();
    probe(7'd8, 1, "R6 store unchanged");
    prepSave(16'h0040, 32'h12345678, 32'hFFFFFFFF);
    doCmd(8'h0C, 1, 0, "R6 matching key");
    pulseReset();
    probe(7'd8, 0, "R6 new word armed");
    chk("R6 readProt released", 32'(readProt), 0);

    // R10 erase beats same-cycle save
    wr(3'd0, 32'hFFFFFFEF);
    probe(7'd16, 1, "R2 group 4 volatile");
    prepSave(16'h0040, 32'h12345678, 32'h00000000);
    eraseAll = 1;
    doCmd(8'h0C, 0, 0, "R10 erase drops save");
    eraseAll = 0;
    probe(7'd16, 0, "R10 volatile cleared by erase");
    pulseReset();
    probe(7'd0, 0, "R10 nothing armed after erase");

    // R9 permanent key
    prepSave(16'h0040, 32'hDEADDEAD, 32'hFFFFFFF7);
    doCmd(8'h0C, 1, 0, "R9 permanent key saved");
    pulseReset();
    probe(7'd12, 1, "R9 group 3 armed");
    prepSave(16'h0040, 32'hDEADDEAD, 32'hFFFFFFFF);
    doCmd(8'h0C, 0, 1, "R9 same key refused");
    pulseReset();
    probe(7'd13, 1, "R9 still protected");
    eraseAll = 1;
    tick();
    eraseAll = 0;
    probe(7'd12, 0, "R10 erase frees permanent lock");
    prepSave(16'h0040, 32'h00000001, 32'hFFFFFFFF);
    doCmd(8'h0C, 1, 0, "R5 blank again after erase");

    // R3 full page sweep
    wr(3'd0, 32'hAAAAAAAA);
    for (int p = 0; p < 128; p++) begin
      probe(7'(p), (p >= 124) ? 1'b1 : (((p / 4) % 2) == 0), "R3 sweep");
      tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule